// File: doc/BRIEF.md
# Byte-Serial Load/Store Unit

This unit performs 32-bit, 16-bit and 8-bit memory loads and stores for a 32-bit core whose external data path is only one byte wide. The core hands it a fully computed 32-bit address, an access size, a direction, a sign-extension choice and 32 bits of store data. The unit then runs one single-byte bus transfer per byte of the access, in ascending address order. It takes the bytes of a store from the low end of the store data. For a load it assembles the returned bytes and widens the result to 32 bits.

The byte bus is synchronous. A transfer is offered with `mem_req` and completes on the first rising clock edge at which `mem_ack` is high. The unit accepts a new request only while it is idle. It reports completion with a single-cycle `done` pulse. Any address alignment is allowed, and address arithmetic wraps modulo 2^32.

Top module: `byte_lsu`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low and `rdata` is zero.
- R2: A request (`start` high) is taken only on a clock edge where `busy` is low. From the following cycle `busy` and `mem_req` are high and `mem_addr` equals the requested address. A `start` pulse while busy has no effect on the transfers.
- R3: The size code sets the number of bus transfers: `size` 2'b00 is one byte, 2'b01 is two bytes, and 2'b10 or 2'b11 is four bytes (word).
- R4: Transfer k (counted from 0) uses address `addr + k` modulo 2^32, in ascending order. For a store, transfer k drives bits [8k+7:8k] of `wdata` on `mem_wdata`, with `mem_we` high.
- R5: A transfer holds `mem_req`, `mem_addr` and `mem_wdata` unchanged until an edge with `mem_ack` high. Then the unit moves to the next transfer or finishes.
- R6: A word load returns byte k from address `addr + k` in `rdata` bits [8k+7:8k] (little-endian).
- R7: With `sext` low, half and byte loads fill the upper bits of `rdata` with zeros.
- R8: With `sext` high, half and byte loads copy bit 15 (half) or bit 7 (byte) of the loaded value into all upper bits of `rdata`.
- R9: `rdata` changes only in the cycle in which `done` is high, and only after a load. A store leaves it unchanged.
- R10: `done` is high for exactly one cycle, the cycle after the final acknowledged transfer. `busy` is low in that cycle and stays high from the cycle after acceptance until then.
- R11: Unaligned addresses are handled with no extra cost, including accesses that wrap from 32'hFFFFFFFF to 32'h00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Access request, taken when idle |
| addr | input | 32 | Byte address of the lowest byte |
| size | input | 2 | 00 byte, 01 half, 1x word |
| sext | input | 1 | Sign-extend half and byte loads |
| write | input | 1 | 1 store, 0 load |
| wdata | input | 32 | Store data, low bytes used |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Extended load result |
| mem_req | output | 1 | Byte transfer offered |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Byte address of the transfer |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with mem_ack |
| mem_ack | input | 1 | Transfer completes at this edge |

## Verification
The assertions assume that `mem_ack` has meaning only while `mem_req` is high, and that `mem_rdata` is valid at the acknowledging edge. They also assume the core may raise `start` at any time, busy or not. The bench's memory model answers from a 256-byte array indexed by the low address bits. It drives `mem_ack` and `start` only on falling edges, and it drives `mem_ack` always high, alternating, or held low. This exercises both the one-transfer-per-cycle case and stalls on every transfer.

// File: rtl/byte_lsu.sv
module byte_lsu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  input  logic        sext,
  input  logic        write,
  input  logic [31:0] wdata,
  output logic        busy,
  output logic        done,
  output logic [31:0] rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ack
);

  logic        act_q, wr_q, sx_q, done_q;
  logic [1:0]  sz_q, idx_q, last_q;
  logic [31:0] base_q, sd_q, acc_q, res_q;
  logic [31:0] acc_nx, widened;
  logic        step, fin;

  assign busy      = act_q;
  assign done      = done_q;
  assign rdata     = res_q;
  assign mem_req   = act_q;
  assign mem_we    = act_q & wr_q;
  assign mem_addr  = base_q + {30'd0, idx_q};
  assign mem_wdata = sd_q[7:0];

  assign step   = act_q & mem_ack;
  assign fin    = step & (idx_q == last_q);
  assign acc_nx = {mem_rdata, acc_q[31:8]};

  always_comb begin
    case (sz_q)
      2'b00:   widened = {{24{sx_q & acc_nx[31]}}, acc_nx[31:24]};
      2'b01:   widened = {{16{sx_q & acc_nx[31]}}, acc_nx[31:16]};
      default: widened = acc_nx;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      sx_q   <= 1'b0;
      sz_q   <= 2'b00;
      idx_q  <= 2'd0;
      last_q <= 2'd0;
      base_q <= 32'd0;
      sd_q   <= 32'd0;
      acc_q  <= 32'd0;
      res_q  <= 32'd0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (!act_q) begin
        if (start) begin
          act_q  <= 1'b1;
          wr_q   <= write;
          sx_q   <= sext;
          sz_q   <= size;
          idx_q  <= 2'd0;
          last_q <= size[1] ? 2'd3 : {1'b0, size[0]};
          base_q <= addr;
          sd_q   <= wdata;
          acc_q  <= 32'd0;
        end
      end else if (step) begin
        idx_q <= idx_q + 2'd1;
        sd_q  <= {8'd0, sd_q[31:8]};
        acc_q <= acc_nx;
        if (fin) begin
          act_q <= 1'b0;
          if (!wr_q) res_q <= widened;
        end
      end
    end
  end

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && mem_req && mem_addr == $past(addr))); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R5

  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !fin) |=> (mem_req && mem_addr == $past(mem_addr) + 32'd1)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && !$past(done))); // R10

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata)); // R9

endmodule

// File: tb/byte_lsu_test.sv
module byte_lsu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] addr = 32'd0;
  logic [1:0]  size = 2'b00;
  logic        sext = 1'b0;
  logic        write = 1'b0;
  logic [31:0] wdata = 32'd0;
  logic        busy, done, mem_req, mem_we;
  logic [31:0] rdata, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_ack = 1'b0;

  byte_lsu uut (.*);

  always #10 clk = ~clk;

  logic [7:0]  mem [0:255];
  logic [31:0] log_a [0:7];
  logic [7:0]  log_d [0:7];
  int          nbeat = 0;
  int          ack_mode = 0;
  int          tests = 0, fails = 0;

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (nbeat < 8) begin
        log_a[nbeat] <= mem_addr;
        log_d[nbeat] <= mem_wdata;
      end
      nbeat <= nbeat + 1;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  always @(negedge clk)
    mem_ack <= (ack_mode == 0) ? 1'b1 : (ack_mode == 1) ? ~mem_ack : 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit w, input bit sx, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    nbeat = 0;
    start = 1'b1; write = w; sext = sx; size = sz; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  localparam int NV = 15;
  localparam logic [99:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 2'b10, 32'h00000010, 32'h0, 32'hB6B7B4B5},
    {1'b0, 1'b0, 2'b01, 32'h00000011, 32'h0, 32'h0000B7B4},
    {1'b0, 1'b1, 2'b01, 32'h00000011, 32'h0, 32'hFFFFB7B4},
    {1'b0, 1'b0, 2'b00, 32'h00000020, 32'h0, 32'h00000085},
    {1'b0, 1'b1, 2'b00, 32'h00000020, 32'h0, 32'hFFFFFF85},
    {1'b0, 1'b1, 2'b00, 32'h00000080, 32'h0, 32'h00000025},
    {1'b0, 1'b1, 2'b01, 32'h00000080, 32'h0, 32'h00002425},
    {1'b0, 1'b0, 2'b10, 32'h00000043, 32'h0, 32'hE3E0E1E6},
    {1'b1, 1'b0, 2'b10, 32'h00000061, 32'h11223344, 32'h0},
    {1'b0, 1'b0, 2'b10, 32'h00000061, 32'h0, 32'h11223344},
    {1'b1, 1'b0, 2'b01, 32'h00000070, 32'hAAAA5566, 32'h0},
    {1'b0, 1'b0, 2'b10, 32'h00000070, 32'h0, 32'hD6D75566},
    {1'b1, 1'b1, 2'b00, 32'h00000090, 32'hFFFFFF99, 32'h0},
    {1'b0, 1'b0, 2'b10, 32'h00000090, 32'h0, 32'h36373499},
    {1'b0, 1'b0, 2'b11, 32'h00000010, 32'h0, 32'hB6B7B4B5}
  };

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    tests++;
    $display("FAIL watchdog actual=%h expected=%h", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 idle flags", {busy, done, mem_req}, 0);
    chk(rdata == 32'd0, "R1 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1 after release", {busy, mem_req}, 0);

    for (int i = 0; i < NV; i++) begin
      logic        w, sx;
      logic [1:0]  sz;
      logic [31:0] a, d, e;
      int          nb;
      bit          ok;
      {w, sx, sz, a, d, e} = VEC[i];
      nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
      ack_mode = i % 2;
      prev = rdata;
      issue(w, sx, sz, a, d);
      chk(busy == 1'b1, "R10 busy after accept", busy, 1);
      wait_done();
      chk(done && !busy, "R10 done with busy low", {done, busy}, 2);
      chk(nbeat == nb, "R3 transfer count", nbeat, nb);
      ok = 1;
      for (int k = 0; k < nb; k++) if (log_a[k] != a + k) ok = 0;
      chk(ok, "R4 ascending addresses", log_a[0], a);
      if (w) begin
        ok = 1;
        for (int k = 0; k < nb; k++) if (log_d[k] != d[8*k +: 8]) ok = 0;
        chk(ok, "R4 store byte order", log_d[0], d[7:0]);
        chk(rdata == prev, "R9 store keeps rdata", rdata, prev);
      end else begin
        chk(rdata == e, sx ? "R8 R6 load sign extend" : "R7 R6 load zero extend", rdata, e);
      end
      @(negedge clk);
      chk(!done, "R10 done single cycle", done, 0);
    end

    ack_mode = 2;
    issue(1'b0, 1'b0, 2'b10, 32'h00000010, 32'h0);
    repeat (5) @(negedge clk);
    chk(busy && mem_addr == 32'h10 && nbeat == 0, "R5 stall holds", mem_addr, 32'h10);
    start = 1'b1; addr = 32'h00000080; size = 2'b00;
    @(negedge clk);
    start = 1'b0;
    chk(mem_addr == 32'h10, "R2 start ignored while busy", mem_addr, 32'h10);
    ack_mode = 0;
    wait_done();
    chk(rdata == 32'hB6B7B4B5 && nbeat == 4, "R2 R5 result after stall", rdata, 32'hB6B7B4B5);
    repeat (4) @(negedge clk);
    chk(!busy && nbeat == 4, "R2 no extra access", nbeat, 4);

    ack_mode = 1;
    issue(1'b0, 1'b0, 2'b10, 32'hFFFFFFFE, 32'h0);
    wait_done();
    chk(rdata == 32'hA4A55A5B, "R11 wrapped load data", rdata, 32'hA4A55A5B);
    chk(log_a[1] == 32'hFFFFFFFF && log_a[2] == 32'h0 && log_a[3] == 32'h1, "R11 address wrap", log_a[2], 0);

    ack_mode = 0;
    issue(1'b1, 1'b0, 2'b01, 32'hFFFFFFFF, 32'h0000BEEF);
    wait_done();
    chk(mem[8'hFF] == 8'hEF && mem[8'h00] == 8'hBE, "R11 wrapped store", {mem[8'hFF], mem[8'h00]}, 16'hEFBE);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule